// File: doc/BRIEF.md
# GPIO Interrupt Detect and Latch Unit

This block watches a bank of general-purpose input pins and turns activity on them into interrupt requests. Every pin has its own configuration word and its own one-bit status flag. The configuration selects a trigger condition: a level, a rising edge, a falling edge or both edges. When that condition occurs, the pin's status flag is set, but only if the pin's latch-enable bit is on. A separate forward-enable bit decides whether a set flag also drives the single combined interrupt line to the processor.

Capture and forwarding are kept apart. An edge that arrives while a pin is masked is still held in its status flag, and the request appears as soon as the pin is unmasked. Software clears a flag by writing to that pin's status word. A parameter chosen per instance decides whether writing 1 or writing 0 performs the clear. A second parameter selects one of two trigger encodings: a two-bit mode field that can detect both edges in hardware, or a one-bit edge/level selector that works together with the polarity bit.

Pin inputs are asynchronous. Each passes through a two-flop synchronizer before detection. Software reaches all words through a simple read/write port. The address is the pin index with one word-select bit below it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every configuration word and every status flag reads zero, and `irq_o` is low.
- R2: The configuration word has these fields: bit 0 forward-enable, bit 1 latch-enable, bit 2 polarity, bits 4:3 trigger mode. With the two-bit variant (DET_W=2), the mode values are 0 level, 1 rising edge, 2 falling edge and 3 either edge. An edge mode does not latch on the opposite edge.
- R3: In level mode (mode 0, DET_W=2), polarity 1 latches while the synchronized pin is high and polarity 0 latches while it is low. While the level persists and latch-enable stays set, a clear is followed at once by a new latch.
- R4: With latch-enable at 0, no trigger sets the status flag. Turning latch-enable on while the pin is steady produces no edge event.
- R5: Latching does not depend on forward-enable. A flag set while masked stays set, and it reaches `irq_o` once forward-enable is written to 1.
- R6: `irq_o` is high exactly when, one cycle earlier, at least one pin had both its status flag and its forward-enable set. Clearing one pin leaves the line high while another pin still qualifies.
- R7: Address bit 0 selects the word: 0 is configuration, 1 is status. A write to status clears the flag when wdata bit 0 equals ACK_HIGH, and has no effect otherwise.
- R8: If a trigger event and a clearing write happen in the same cycle, the status flag stays set.
- R9: A read returns the addressed pin's word in `rdata`, with `rd_valid` high, one cycle after `rd_en`. Status reads return the flag in bit 0.
- R10: In the one-bit variant (DET_W=1), bit 3 selects edge (1) or level (0), polarity selects rising/high (1) or falling/low (0), and bit 4 always reads 0.
- R11: A pin change sets its status flag at the third rising clock edge after the change. It appears on `irq_o` at the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | {pin index, word select} |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rdata valid this cycle |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
A pin change becomes a set status flag three clock edges later and reaches `irq_o` one edge after that. The bench drives every input on falling edges and counts falling edges to sample `irq_o` just before and just after that fourth edge. Read data is due one edge after the read strobe: the read task queues the expected word, and a monitor compares it on the falling edge where `rd_valid` is seen. The same-cycle case for event against clear is lined up so that the write strobe is sampled on the exact edge where the synchronized falling edge is detected.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CFG_W = 5;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

  typedef struct packed {
    logic [1:0] det;
    logic       pol;
    logic       raw;
    logic       ien;
  } pin_cfg_t;

  localparam logic SEL_CFG  = 1'b0;
  localparam logic SEL_STAT = 1'b1;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int DET_W    = 2,
  parameter bit ACK_HIGH = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     level_i,
  input  logic     cfg_we_i,
  input  pin_cfg_t cfg_i,
  input  logic     st_we_i,
  input  logic     st_bit_i,
  output pin_cfg_t cfg_o,
  output logic     status_o,
  output logic     fire_o
);
  pin_cfg_t cfg_q, cfg_next;
  logic prev_q, status_q;
  logic rise, fall, hit, latch, clr;

  // registered copy follows the input every cycle, independent of config
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  generate
    if (DET_W >= 2) begin : g_two_bit
      always_comb begin
        cfg_next = cfg_i;
        case (det_mode_e'(cfg_q.det))
          DET_LEVEL: hit = (level_i == cfg_q.pol);
          DET_RISE:  hit = rise;
          DET_FALL:  hit = fall;
          default:   hit = rise | fall;
        endcase
      end
    end else begin : g_one_bit
      logic unused_det_hi;
      assign unused_det_hi = cfg_i.det[1];
      always_comb begin
        cfg_next        = cfg_i;
        cfg_next.det[1] = 1'b0;
        if (cfg_q.det[0]) hit = cfg_q.pol ? rise : fall;
        else              hit = (level_i == cfg_q.pol);
      end
    end
  endgenerate

  assign latch = cfg_q.raw & hit;
  assign clr   = st_we_i & (st_bit_i == ACK_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_next;
      if (latch)    status_q <= 1'b1;
      else if (clr) status_q <= 1'b0;
    end
  end

  assign cfg_o    = cfg_q;
  assign status_o = status_q;
  assign fire_o   = status_q & cfg_q.ien;

  // R4: a flag only rises when latching was enabled
  a_r4_needs_raw: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(cfg_q.raw));
  // R5: a set flag is kept until a clear, masked or not
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr) |=> status_q);
  // R7: a clearing write without an event empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !latch) |=> !status_q);
  // R8: event and clear in one cycle leave the flag set
  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (st_we_i && latch) |=> status_q);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  pin_cfg_t [NUM_PINS-1:0]       cfg_all,
  input  logic [NUM_PINS-1:0]           status_all,
  output logic [NUM_PINS-1:0]           cfg_we,
  output logic [NUM_PINS-1:0]           st_we,
  output pin_cfg_t                      cfg_wr,
  output logic                          st_bit,
  output logic [DATA_W-1:0]             rdata,
  output logic                          rd_valid
);
  localparam int PIN_W = ADDR_W - 1;

  logic [PIN_W-1:0] pin_idx;
  logic             sel, in_range;
  logic [DATA_W-1:0] rd_word;
  logic unused_wdata;

  assign pin_idx  = addr[ADDR_W-1:1];
  assign sel      = addr[0];
  assign in_range = (int'(pin_idx) < NUM_PINS);
  assign cfg_wr   = pin_cfg_t'(wdata[CFG_W-1:0]);
  assign st_bit   = wdata[0];
  assign unused_wdata = ^wdata[DATA_W-1:CFG_W];

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_dec
      assign cfg_we[p] = wr_en && (sel == SEL_CFG)  && (pin_idx == PIN_W'(p));
      assign st_we[p]  = wr_en && (sel == SEL_STAT) && (pin_idx == PIN_W'(p));
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (in_range) begin
      if (sel == SEL_STAT) rd_word = DATA_W'(status_all[pin_idx]);
      else                 rd_word = DATA_W'(cfg_all[pin_idx]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R9: read strobe yields exactly one valid cycle after it
  a_r9_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R7: at most one word written per cycle
  a_r7_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_we, st_we}));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int DET_W       = 2,
  parameter bit ACK_HIGH    = 1'b1,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_PINS) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                rd_valid,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] cfg_we, st_we, status_all, fire;
  pin_cfg_t [NUM_PINS-1:0] cfg_all;
  pin_cfg_t cfg_wr;
  logic st_bit;
  logic irq_q;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cfg_all(cfg_all), .status_all(status_all),
    .cfg_we(cfg_we), .st_we(st_we), .cfg_wr(cfg_wr), .st_bit(st_bit),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpio_irq_pin #(.DET_W(DET_W), .ACK_HIGH(ACK_HIGH)) u_pin (
        .clk(clk), .rst(rst), .level_i(pin_s[p]),
        .cfg_we_i(cfg_we[p]), .cfg_i(cfg_wr),
        .st_we_i(st_we[p]), .st_bit_i(st_bit),
        .cfg_o(cfg_all[p]), .status_o(status_all[p]), .fire_o(fire[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |fire;
  end

  assign irq_o = irq_q;

  // R6: summary follows the qualified flags one cycle later
  a_r6_summary_on: assert property (@(posedge clk) disable iff (rst)
    (|fire) |=> irq_o);
  a_r6_summary_off: assert property (@(posedge clk) disable iff (rst)
    !(|fire) |=> !irq_o);
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
  localparam logic SC = 1'b0;
  localparam logic SS = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] pins = '0;
  logic wr0 = 1'b0, wr1 = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic rv0, rv1, irq0, irq1;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    bit          care;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t q0[$];
  exp_t q1[$];

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(8), .DET_W(2), .ACK_HIGH(1'b1)) u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(wr0), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata0), .rd_valid(rv0), .irq_o(irq0)
  );

  gpio_irq_ctrl #(.NUM_PINS(8), .DET_W(1), .ACK_HIGH(1'b0)) u1 (
    .clk(clk), .rst(rst), .pin_i(pins), .wr_en(wr1), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata1), .rd_valid(rv1), .irq_o(irq1)
  );

  function automatic void chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] cv(input int det, input bit pol, input bit raw, input bit ien);
    logic [1:0] d2;
    d2 = det[1:0];
    return {27'b0, d2, pol, raw, ien};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit t0, input bit t1, input int pin, input logic sel, input logic [31:0] d);
    logic [2:0] p3;
    p3 = pin[2:0];
    @(negedge clk);
    wr0 = t0; wr1 = t1; addr = {p3, sel}; wdata = d;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input int pin, input logic sel, input bit c0, input logic [31:0] e0,
                    input bit c1, input logic [31:0] e1, input string tag);
    exp_t a, b;
    logic [2:0] p3;
    p3 = pin[2:0];
    a.care = c0; a.exp = e0; a.tag = {tag, " u0"};
    b.care = c1; b.exp = e1; b.tag = {tag, " u1"};
    @(negedge clk);
    rd_en = 1'b1; addr = {p3, sel};
    q0.push_back(a);
    q1.push_back(b);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare read results as they appear (R9)
  always @(negedge clk) begin
    if (!rst && rv0) begin
      if (q0.size() == 0) chk(32'd1, 32'd0, "R9 unexpected rd_valid u0");
      else begin
        exp_t it;
        it = q0.pop_front();
        if (it.care) chk(rdata0, it.exp, it.tag);
      end
    end
    if (!rst && rv1) begin
      if (q1.size() == 0) chk(32'd1, 32'd0, "R9 unexpected rd_valid u1");
      else begin
        exp_t it;
        it = q1.pop_front();
        if (it.care) chk(rdata1, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);

    // R1 reset state
    rd(0, SC, 1, 32'h0, 1, 32'h0, "R1 cfg after reset");
    rd(3, SS, 1, 32'h0, 1, 32'h0, "R1 status after reset");
    chk(irq0, 1'b0, "R1 irq u0");
    chk(irq1, 1'b0, "R1 irq u1");

    // rising edge on pin0, both instances, with timing (R11, R2, R9)
    wr(1, 1, 0, SC, cv(1, 1, 1, 1));
    rd(0, SC, 1, 32'h0F, 1, 32'h0F, "R9 cfg readback pin0");
    @(negedge clk); pins[0] = 1'b1;
    tick(3);
    chk(irq0, 1'b0, "R11 irq before 4th edge u0");
    chk(irq1, 1'b0, "R11 irq before 4th edge u1");
    tick(1);
    chk(irq0, 1'b1, "R11 irq at 4th edge u0");
    chk(irq1, 1'b1, "R11 irq at 4th edge u1");
    rd(0, SS, 1, 32'h1, 1, 32'h1, "R2 rising latched");

    // R7 acknowledge polarity per instance
    wr(1, 1, 0, SS, 32'h1);
    rd(0, SS, 1, 32'h0, 1, 32'h1, "R7 write one");
    wr(1, 1, 0, SS, 32'h0);
    rd(0, SS, 1, 32'h0, 1, 32'h0, "R7 write zero");
    tick(1);
    chk(irq0, 1'b0, "R6 irq drops u0");
    chk(irq1, 1'b0, "R6 irq drops u1");

    // R2 rising mode ignores falling edge
    @(negedge clk); pins[0] = 1'b0;
    tick(5);
    rd(0, SS, 1, 32'h0, 1, 32'h0, "R2 rising ignores fall");

    // R2 falling mode, masked (R5)
    wr(1, 0, 1, SC, cv(2, 1, 1, 0));
    @(negedge clk); pins[1] = 1'b1;
    tick(5);
    rd(1, SS, 1, 32'h0, 0, 32'h0, "R2 falling ignores rise");
    @(negedge clk); pins[1] = 1'b0;
    tick(5);
    rd(1, SS, 1, 32'h1, 0, 32'h0, "R2 falling latched");
    chk(irq0, 1'b0, "R5 masked flag kept off irq");
    wr(1, 0, 1, SC, cv(2, 1, 1, 1));
    tick(2);
    chk(irq0, 1'b1, "R5 unmask forwards held flag");
    wr(1, 0, 1, SS, 32'h1);
    tick(2);
    chk(irq0, 1'b0, "R6 irq clears after ack");

    // R2 both edges on pin2
    wr(1, 0, 2, SC, cv(3, 1, 1, 0));
    @(negedge clk); pins[2] = 1'b1;
    tick(5);
    rd(2, SS, 1, 32'h1, 0, 32'h0, "R2 both rise");
    wr(1, 0, 2, SS, 32'h1);
    rd(2, SS, 1, 32'h0, 0, 32'h0, "R2 both cleared");
    @(negedge clk); pins[2] = 1'b0;
    tick(5);
    rd(2, SS, 1, 32'h1, 0, 32'h0, "R2 both fall");
    wr(1, 0, 2, SS, 32'h1);
    rd(2, SS, 1, 32'h0, 0, 32'h0, "R2 both cleared again");

    // R3 level modes on pin3
    wr(1, 0, 3, SC, cv(0, 1, 1, 0));
    @(negedge clk); pins[3] = 1'b1;
    tick(5);
    rd(3, SS, 1, 32'h1, 0, 32'h0, "R3 level high latched");
    wr(1, 0, 3, SS, 32'h1);
    tick(2);
    rd(3, SS, 1, 32'h1, 0, 32'h0, "R3 relatch while high");
    @(negedge clk); pins[3] = 1'b0;
    tick(5);
    wr(1, 0, 3, SS, 32'h1);
    rd(3, SS, 1, 32'h0, 0, 32'h0, "R3 level gone then clear");
    wr(1, 0, 3, SC, cv(0, 0, 1, 0));
    tick(3);
    rd(3, SS, 1, 32'h1, 0, 32'h0, "R3 level low latched");
    @(negedge clk); pins[3] = 1'b1;
    tick(5);
    wr(1, 0, 3, SS, 32'h1);
    rd(3, SS, 1, 32'h0, 0, 32'h0, "R3 low released then clear");

    // R4 no false edge from enabling, and latch-enable off
    @(negedge clk); pins[4] = 1'b1;
    tick(5);
    wr(1, 0, 4, SC, cv(1, 1, 1, 0));
    tick(5);
    rd(4, SS, 1, 32'h0, 0, 32'h0, "R4 enable on steady high");
    wr(1, 0, 5, SC, cv(1, 1, 0, 0));
    @(negedge clk); pins[5] = 1'b1;
    tick(5);
    rd(5, SS, 1, 32'h0, 0, 32'h0, "R4 latch disabled");

    // R8 event and clear in the same cycle
    wr(1, 0, 6, SC, cv(3, 1, 1, 0));
    @(negedge clk); pins[6] = 1'b1;
    tick(5);
    rd(6, SS, 1, 32'h1, 0, 32'h0, "R8 setup latched");
    @(negedge clk); pins[6] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr0 = 1'b1; addr = {3'd6, SS}; wdata = 32'h1;
    @(negedge clk);
    wr0 = 1'b0;
    rd(6, SS, 1, 32'h1, 0, 32'h0, "R8 event beats clear");
    wr(1, 0, 6, SS, 32'h1);
    rd(6, SS, 1, 32'h0, 0, 32'h0, "R8 clear without event");

    // R10 one-bit variant on u1
    wr(0, 1, 7, SC, cv(1, 0, 1, 0));
    @(negedge clk); pins[7] = 1'b1;
    tick(5);
    rd(7, SS, 0, 32'h0, 1, 32'h0, "R10 falling ignores rise");
    @(negedge clk); pins[7] = 1'b0;
    tick(5);
    rd(7, SS, 0, 32'h0, 1, 32'h1, "R10 falling latched");
    wr(0, 1, 7, SS, 32'h0);
    rd(7, SS, 0, 32'h0, 1, 32'h0, "R10 cleared by zero");
    wr(0, 1, 7, SC, cv(0, 1, 1, 0));
    @(negedge clk); pins[7] = 1'b1;
    tick(5);
    rd(7, SS, 0, 32'h0, 1, 32'h1, "R10 level high latched");
    @(negedge clk); pins[7] = 1'b0;
    tick(5);
    wr(0, 1, 7, SS, 32'h0);
    rd(7, SS, 0, 32'h0, 1, 32'h0, "R10 level released");
    wr(0, 1, 6, SC, 32'h1E);
    rd(6, SC, 1, 32'h1E, 1, 32'h0E, "R10 mode bit 4 reads zero");

    // R6 several pins feeding the summary
    wr(1, 0, 2, SC, cv(3, 1, 1, 1));
    @(negedge clk); pins[0] = 1'b1; pins[2] = 1'b1;
    tick(5);
    chk(irq0, 1'b1, "R6 two pins pending");
    wr(1, 0, 0, SS, 32'h1);
    tick(2);
    chk(irq0, 1'b1, "R6 other pin holds irq");
    wr(1, 0, 2, SS, 32'h1);
    tick(2);
    chk(irq0, 1'b0, "R6 all cleared");

    tick(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule